// File: doc/BRIEF.md
# Two-Source Event Fragment Merger

The merger joins the fragments produced by two 64-bit link sources into one output stream, so that two small sources look like a single larger one to the stage downstream. Each source writes into its own buffer FIFO. The output side reads from only one buffer at a time. It takes one complete fragment from source A, then the fragment for the same event from source B, and sends the two out back to back as one merged fragment. After that it returns to source A.

Every word is 64 data bits plus a control flag. A control word whose bits [63:60] equal 4'h5 is a header, and its bits [55:32] hold the 24-bit trigger number. A control word whose bits [63:60] equal 4'hA is a trailer and ends the fragment. All words are forwarded unchanged, including both headers and both trailers. When source B's header carries a trigger number different from source A's, the merger raises a sticky error flag, but the data still passes through. Each source gets a busy signal when the free space in its buffer falls below a margin set by a parameter. This margin covers the link round trip.

The controller has four states. HUNT_A waits for a header at the head of buffer A and discards any other word found there. When a header appears, the state goes to PASS_A and A's trigger number is latched. PASS_A forwards A's words and goes to HUNT_B once A's trailer is accepted. HUNT_B discards non-header words from buffer B. When B's header appears, the trigger numbers are compared and the state goes to PASS_B. PASS_B forwards B's words and goes back to HUNT_A once B's trailer is accepted.

Top module: `frag_merger`

## Requirements
- R1: After reset, m_valid, a_busy, b_busy and id_err are all 0.
- R2: A fragment from source A is sent whole, from its header (ctrl=1, bits[63:60]=4'h5) to its trailer (ctrl=1, bits[63:60]=4'hA), and is followed at once by the matching fragment from source B.
- R3: Over several events the output alternates A, B, A, B, and each source's fragments keep their arrival order.
- R4: Words already held for source B are not sent while source A's fragment is still pending, even if B's data arrived first.
- R5: If the trigger number in B's header (bits[55:32]) differs from the one in the preceding A header, id_err goes to 1. It stays at 1 until reset, and the words are still forwarded.
- R6: When the trigger numbers match, id_err stays at 0.
- R7: While m_valid is 1 and m_ready is 0, m_valid stays at 1 and m_data and m_ctrl hold their values. No word is lost or sent twice under any ready pattern.
- R8: A source's busy output is 1 exactly when DEPTH minus the words held in its buffer is less than GAP.
- R9: Any word other than a header that is at the head of a buffer while the controller is waiting for that source's header is discarded and never output.
- R10: Reset in the middle of a fragment empties both buffers, clears id_err and returns the controller to waiting for a header on source A.
- R11: The control flag of each word is sent on m_ctrl together with that same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_data | input | 64 | Source A word |
| a_ctrl | input | 1 | Source A control flag |
| a_valid | input | 1 | Source A word strobe |
| a_busy | output | 1 | Backpressure to source A |
| b_data | input | 64 | Source B word |
| b_ctrl | input | 1 | Source B control flag |
| b_valid | input | 1 | Source B word strobe |
| b_busy | output | 1 | Backpressure to source B |
| m_data | output | 64 | Merged output word |
| m_ctrl | output | 1 | Control flag of the output word |
| m_valid | output | 1 | Output word available |
| m_ready | input | 1 | Downstream accepts the word |
| id_err | output | 1 | Sticky trigger-number mismatch |

## Verification
The merge is exercised with several input patterns, and each one separates a different failure:
- B data arriving before A shows whether the output really serves only one source at a time.
- Several events queued in both buffers show whether the alternation and the per-source order hold.
- Empty and long payloads show whether the trailer alone ends a fragment.
- Stray words placed ahead of the headers show whether the hunt states discard them.
- Matched and mismatched trigger numbers, followed by a matched event, show whether the compare works and whether the flag is sticky.
- A toggling ready, a filling buffer and a reset in mid-fragment expose lost or duplicated words, a wrong busy threshold, and stale data surviving reset.

// File: rtl/mrg_pkg.sv
package mrg_pkg;
    localparam int WORD_W = 64;
    localparam int ID_LSB = 32;
    localparam int ID_W   = 24;
    localparam logic [3:0] TAG_SOF = 4'h5;
    localparam logic [3:0] TAG_EOF = 4'hA;

    typedef enum logic [1:0] {
        HUNT_A = 2'd0,
        PASS_A = 2'd1,
        HUNT_B = 2'd2,
        PASS_B = 2'd3
    } mrg_state_e;
endpackage

// File: rtl/frag_fifo.sv
module frag_fifo #(
    parameter int W     = 65,
    parameter int DEPTH = 4096,
    parameter int GAP   = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    output logic         full,
    output logic         busy,
    input  logic         rd_en,
    output logic [W-1:0] rd_word,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEP_V = (AW+1)'(DEPTH);
    localparam logic [AW:0] LIM_V = (AW+1)'(DEPTH - GAP);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   cnt;
    logic          wr_ok, rd_ok;

    assign wr_ok   = wr_en && !full;
    assign rd_ok   = rd_en && !empty;
    assign full    = (cnt == DEP_V);
    assign empty   = (cnt == '0);
    assign busy    = (cnt > LIM_V);
    assign rd_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R7
    rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

    // R8
    busy_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !full);
endmodule

// File: rtl/hdr_cmp.sv
module hdr_cmp #(
    parameter int IDW = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic [IDW-1:0] cap_id,
    input  logic           chk_en,
    input  logic [IDW-1:0] chk_id,
    output logic           mismatch
);
    logic [IDW-1:0] held_id;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_id  <= '0;
            mismatch <= 1'b0;
        end else begin
            if (cap_en) held_id <= cap_id;
            if (chk_en && (chk_id != held_id)) mismatch <= 1'b1;
        end
    end

    // R5
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> mismatch);
endmodule

// File: rtl/frag_merger.sv
module frag_merger
    import mrg_pkg::*;
#(
    parameter int DEPTH = 4096,
    parameter int GAP   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] a_data,
    input  logic        a_ctrl,
    input  logic        a_valid,
    output logic        a_busy,
    input  logic [63:0] b_data,
    input  logic        b_ctrl,
    input  logic        b_valid,
    output logic        b_busy,
    output logic [63:0] m_data,
    output logic        m_ctrl,
    output logic        m_valid,
    input  logic        m_ready,
    output logic        id_err
);
    localparam int FW = WORD_W + 1;

    logic [1:0]    push, full, empty, busy, pop, is_sof, is_eof;
    logic [FW-1:0] wr_w [2];
    logic [FW-1:0] head [2];
    mrg_state_e    state, nxt;
    logic          sel, cap, chk;

    assign wr_w[0] = {a_ctrl, a_data};
    assign wr_w[1] = {b_ctrl, b_data};
    assign push    = {b_valid, a_valid};
    assign a_busy  = busy[0];
    assign b_busy  = busy[1];

    for (genvar p = 0; p < 2; p++) begin : g_port
        frag_fifo #(.W(FW), .DEPTH(DEPTH), .GAP(GAP)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (push[p]),
            .wr_word (wr_w[p]),
            .full    (full[p]),
            .busy    (busy[p]),
            .rd_en   (pop[p]),
            .rd_word (head[p]),
            .empty   (empty[p])
        );
        assign is_sof[p] = !empty[p] && head[p][FW-1] &&
                           (head[p][WORD_W-1 -: 4] == TAG_SOF);
        assign is_eof[p] = !empty[p] && head[p][FW-1] &&
                           (head[p][WORD_W-1 -: 4] == TAG_EOF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= HUNT_A;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            HUNT_A: if (is_sof[0])             nxt = PASS_A;
            PASS_A: if (pop[0] && is_eof[0])   nxt = HUNT_B;
            HUNT_B: if (is_sof[1])             nxt = PASS_B;
            PASS_B: if (pop[1] && is_eof[1])   nxt = HUNT_A;
        endcase
    end

    always_comb begin
        pop     = '0;
        m_valid = 1'b0;
        sel     = 1'b0;
        cap     = 1'b0;
        chk     = 1'b0;
        unique case (state)
            HUNT_A: begin
                pop[0] = !empty[0] && !is_sof[0];
                cap    = is_sof[0];
            end
            PASS_A: begin
                m_valid = !empty[0];
                pop[0]  = m_valid && m_ready;
            end
            HUNT_B: begin
                sel    = 1'b1;
                pop[1] = !empty[1] && !is_sof[1];
                chk    = is_sof[1];
            end
            PASS_B: begin
                sel     = 1'b1;
                m_valid = !empty[1];
                pop[1]  = m_valid && m_ready;
            end
        endcase
    end

    assign m_data = head[sel][WORD_W-1:0];
    assign m_ctrl = head[sel][FW-1];

    hdr_cmp #(.IDW(ID_W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap),
        .cap_id   (head[0][ID_LSB +: ID_W]),
        .chk_en   (chk),
        .chk_id   (head[1][ID_LSB +: ID_W]),
        .mismatch (id_err)
    );

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_ctrl)));

    // R2
    a_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PASS_A && pop[0] && is_eof[0]) |=> (state == HUNT_B && !m_valid));
endmodule

// File: tb/test_frag_merger.sv
module test_frag_merger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a_data = '0, b_data = '0;
    logic        a_ctrl = 1'b0, b_ctrl = 1'b0, a_valid = 1'b0, b_valid = 1'b0;
    logic        a_busy, b_busy, m_ctrl, m_valid, id_err;
    logic [63:0] m_data;
    logic        m_ready = 1'b1;

    int nchk = 0;
    int nerr = 0;
    logic [64:0] got [$];
    logic [64:0] exp [$];

    always #5 clk = ~clk;

    frag_merger #(.DEPTH(32), .GAP(16)) i_frag_merger (
        .clk(clk), .rst_n(rst_n),
        .a_data(a_data), .a_ctrl(a_ctrl), .a_valid(a_valid), .a_busy(a_busy),
        .b_data(b_data), .b_ctrl(b_ctrl), .b_valid(b_valid), .b_busy(b_busy),
        .m_data(m_data), .m_ctrl(m_ctrl), .m_valid(m_valid), .m_ready(m_ready),
        .id_err(id_err)
    );

    always @(negedge clk)
        if (rst_n && m_valid && m_ready) got.push_back({m_ctrl, m_data});

    function automatic logic [64:0] hdr_w(int id);
        return {1'b1, 4'h5, 4'h0, id[23:0], 32'h0};
    endfunction
    function automatic logic [64:0] pay_w(int port, int id, int k);
        return {1'b0, port[7:0], id[23:0], k[31:0]};
    endfunction
    function automatic logic [64:0] eof_w(int len);
        return {1'b1, 4'hA, 28'h0, len[31:0]};
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic [64:0] act, logic [64:0] want);
        nchk++;
        if (act !== want) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, want);
        end
    endtask

    task automatic push_word(int port, logic [64:0] w);
        if (port == 0) begin {a_ctrl, a_data} = w; a_valid = 1'b1; end
        else           begin {b_ctrl, b_data} = w; b_valid = 1'b1; end
        tick();
        a_valid = 1'b0;
        b_valid = 1'b0;
    endtask

    task automatic send_frag(int port, int id, int n);
        push_word(port, hdr_w(id));
        for (int k = 0; k < n; k++) push_word(port, pay_w(port, id, k));
        push_word(port, eof_w(n + 2));
    endtask

    task automatic expect_frag(int port, int id, int n);
        exp.push_back(hdr_w(id));
        for (int k = 0; k < n; k++) exp.push_back(pay_w(port, id, k));
        exp.push_back(eof_w(n + 2));
    endtask

    task automatic compare_stream(string req);
        for (int i = 0; i < 300 && got.size() < exp.size(); i++) tick();
        repeat (10) tick();
        check({req, " word count"}, 65'(got.size()), 65'(exp.size()));
        for (int i = 0; i < exp.size() && i < got.size(); i++)
            check(req, got[i], exp[i]);
        got.delete();
        exp.delete();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
        got.delete();
        exp.delete();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 m_valid", 65'(m_valid), 65'(0));
        check("R1 a_busy", 65'(a_busy), 65'(0));
        check("R1 b_busy", 65'(b_busy), 65'(0));
        check("R1 id_err", 65'(id_err), 65'(0));
    endtask

    task automatic t_basic();
        m_ready = 1'b1;
        send_frag(1, 5, 1);
        repeat (4) tick();
        check("R4 B held while A empty", 65'(m_valid), 65'(0));
        send_frag(0, 5, 2);
        expect_frag(0, 5, 2);
        expect_frag(1, 5, 1);
        compare_stream("R2 R11 merged pair");
        check("R6 matched ids", 65'(id_err), 65'(0));
    endtask

    task automatic t_alternate();
        send_frag(0, 10, 3);
        send_frag(0, 11, 1);
        send_frag(1, 10, 2);
        send_frag(1, 11, 0);
        expect_frag(0, 10, 3);
        expect_frag(1, 10, 2);
        expect_frag(0, 11, 1);
        expect_frag(1, 11, 0);
        compare_stream("R3 alternation");
    endtask

    task automatic t_stray();
        push_word(0, pay_w(0, 99, 0));
        push_word(0, eof_w(7));
        send_frag(0, 20, 1);
        push_word(1, pay_w(1, 98, 3));
        send_frag(1, 20, 1);
        expect_frag(0, 20, 1);
        expect_frag(1, 20, 1);
        compare_stream("R9 strays dropped");
    endtask

    task automatic t_stall();
        m_ready = 1'b0;
        send_frag(0, 40, 2);
        send_frag(1, 40, 1);
        repeat (3) tick();
        check("R7 valid under stall", 65'(m_valid), 65'(1));
        check("R7 head word", {m_ctrl, m_data}, hdr_w(40));
        repeat (3) tick();
        check("R7 still held", {m_valid, m_ctrl, m_data[62:0]},
              {1'b1, hdr_w(40)[64], hdr_w(40)[62:0]});
        for (int i = 0; i < 40; i++) begin
            m_ready = i[0];
            tick();
        end
        m_ready = 1'b1;
        expect_frag(0, 40, 2);
        expect_frag(1, 40, 1);
        compare_stream("R7 toggled ready");
    endtask

    task automatic t_busy();
        m_ready = 1'b0;
        push_word(0, hdr_w(50));
        for (int k = 0; k < 15; k++) push_word(0, pay_w(0, 50, k));
        check("R8 16 held not busy", 65'(a_busy), 65'(0));
        push_word(0, pay_w(0, 50, 15));
        check("R8 17 held busy", 65'(a_busy), 65'(1));
        check("R8 other side idle", 65'(b_busy), 65'(0));
        push_word(0, eof_w(18));
        m_ready = 1'b1;
        send_frag(1, 50, 0);
        expect_frag(0, 50, 16);
        expect_frag(1, 50, 0);
        compare_stream("R8 drain");
        check("R8 busy released", 65'(a_busy), 65'(0));
    endtask

    task automatic t_mismatch();
        send_frag(0, 30, 1);
        send_frag(1, 31, 1);
        expect_frag(0, 30, 1);
        expect_frag(1, 31, 1);
        compare_stream("R5 mismatch forwarded");
        check("R5 flag set", 65'(id_err), 65'(1));
        send_frag(0, 32, 0);
        send_frag(1, 32, 0);
        expect_frag(0, 32, 0);
        expect_frag(1, 32, 0);
        compare_stream("R5 later pair");
        check("R5 flag sticky", 65'(id_err), 65'(1));
    endtask

    task automatic t_reset_mid();
        m_ready = 1'b0;
        push_word(0, hdr_w(60));
        push_word(0, pay_w(0, 60, 0));
        push_word(1, pay_w(1, 60, 9));
        tick();
        check("R10 pending before reset", 65'(m_valid), 65'(1));
        do_reset();
        check("R10 no output after reset", 65'(m_valid), 65'(0));
        check("R10 id_err cleared", 65'(id_err), 65'(0));
        m_ready = 1'b1;
        send_frag(0, 61, 1);
        send_frag(1, 61, 1);
        expect_frag(0, 61, 1);
        expect_frag(1, 61, 1);
        compare_stream("R10 clean restart");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_alternate();
        t_stray();
        t_stall();
        t_busy();
        t_mismatch();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule